// File: doc/BRIEF.md
# Speculative Decision-Feedback Equalizer

This block turns one soft received sample per clock into one binary symbol decision. It cancels trailing intersymbol interference with a set of N feedback weights. A direct decision-feedback loop multiplies the recent decisions by those weights and subtracts the sum before slicing, and that arithmetic limits the clock rate. This design works out, for each incoming sample, the slicer input that every possible pattern of the previous N decisions would produce. There are 2^N such candidate values. It slices all of them at once and registers their sign bits. When the previous decisions are known, they select one registered sign bit through a multiplexer. The only logic left inside the recursion is that multiplexer tree and the decision history register.

The feedforward filter upstream supplies the soft sample and a qualifying strobe. The feedback weights come in on a flat port, and a separate adaptation engine can update them between any two samples. Decisions leave the block with their own strobe, in the order the samples arrived.

Top module: `dfe_unrolled`

## Requirements
- R1: Every accepted sample y(n) yields a decision bit, where 1 stands for +1 and 0 stands for -1. The bit is 1 exactly when y(n) - sum over k=1..N of d_k * a(n-k) is zero or greater. The sample and the weights are two's complement, and weight d_k sits at bits [(k-1)*TAP_W +: TAP_W] of `tapWeights`.
- R2: A candidate slicer input that is exactly zero is decided as 1, and a value of -1 is decided as 0.
- R3: A sample accepted at a rising edge with `sampleValid` high gives a decision that is presented, with `decisionValid` high for that one cycle, after the second rising edge that follows. Decisions come out in the order the samples were accepted, one for each sample.
- R4: Cycles with `sampleValid` low shift nothing into the decision history, so gaps between samples do not change the result.
- R5: After reset `decisionValid` and `decisionBit` are 0, and the decision history holds -1 in all N positions.
- R6: The weights are taken in the same cycle as the sample they apply to. A weight change between two accepted samples applies from the later sample on.
- R7: `decisionBit` keeps its value in every cycle in which `decisionValid` is low.
- R8: Full-scale negative and positive samples, combined with extreme weights, are decided correctly and do not wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `sampleIn` and `tapWeights` in this cycle |
| sampleIn | input | SAMPLE_W | Soft sample from the feedforward filter, signed |
| tapWeights | input | NUM_TAPS*TAP_W | Feedback weights d1..dN, signed, d1 in the low bits |
| decisionValid | output | 1 | A new decision is present |
| decisionBit | output | 1 | Decision, 1 = +1, 0 = -1 |

## Verification
Suppose the history register holds a wrong bit, or the multiplexer decodes its select code in the wrong order. The next sample whose candidates differ in that position then gives a decision that differs from a direct-form reference. Because the error feeds back, the decisions after it usually diverge as well, so the fault reaches `decisionBit` within a few samples. A stray shift during an idle cycle shows up the same way. The bench uses random weights on every sample and random idle gaps, and it compares each decision with the reference as that decision leaves the block.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCand;  // capture candidate signs of the incoming sample
    logic commit;    // pick one candidate and shift it into history
  } dfe_strobe_t;

  // Accumulator width that holds y plus N weights with no overflow
  function automatic int accWidth(int sampleW, int tapW, int numTaps);
    int widest;
    widest = (sampleW > tapW) ? sampleW : tapW;
    return widest + $clog2(numTaps + 1) + 1;
  endfunction

endpackage

// File: rtl/dfe_cand_unit.sv
// One speculative slicer: assumes one fixed pattern of past decisions.
module dfe_cand_unit #(
  parameter int SAMPLE_W = 8,
  parameter int TAP_W    = 6,
  parameter int NUM_TAPS = 6,
  parameter int PATTERN  = 0
) (
  input  logic signed [SAMPLE_W-1:0]       sampleIn,
  input  logic        [NUM_TAPS*TAP_W-1:0] tapWeights,
  output logic                             signBit
);
  localparam int ACC_W = dfe_pkg::accWidth(SAMPLE_W, TAP_W, NUM_TAPS);

  logic signed [ACC_W-1:0] acc;
  logic signed [TAP_W-1:0] tapVal;

  always_comb begin
    acc    = ACC_W'(sampleIn);
    tapVal = '0;
    for (int k = 1; k <= NUM_TAPS; k++) begin
      tapVal = tapWeights[(k-1)*TAP_W +: TAP_W];
      // Pattern bit for a(n-k): a(n-1) is the most significant bit
      if (((PATTERN >> (NUM_TAPS - k)) & 1) != 0)
        acc = acc - ACC_W'(tapVal);  // assumed a = +1
      else
        acc = acc + ACC_W'(tapVal);  // assumed a = -1
    end
    signBit = ~acc[ACC_W-1];
  end
endmodule

// File: rtl/dfe_ctrl.sv
module dfe_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  output dfe_pkg::dfe_strobe_t strobe,
  output logic                decisionValid
);
  logic candValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candValid     <= 1'b0;
      decisionValid <= 1'b0;
    end else begin
      candValid     <= sampleValid;
      decisionValid <= candValid;
    end
  end

  always_comb begin
    strobe.loadCand = sampleValid;
    strobe.commit   = candValid;
  end
endmodule

// File: rtl/dfe_datapath.sv
module dfe_datapath #(
  parameter int SAMPLE_W = 8,
  parameter int TAP_W    = 6,
  parameter int NUM_TAPS = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dfe_pkg::dfe_strobe_t             strobe,
  input  logic signed [SAMPLE_W-1:0]       sampleIn,
  input  logic        [NUM_TAPS*TAP_W-1:0] tapWeights,
  output logic                             decisionBit,
  output logic        [NUM_TAPS-1:0]       histState
);
  localparam int NUM_CAND = 1 << NUM_TAPS;

  logic [NUM_CAND-1:0] candSign;
  logic [NUM_CAND-1:0] candReg;
  logic                pickBit;

  // All 2^N speculative slicers, outside the recursion
  for (genvar j = 0; j < NUM_CAND; j++) begin : gCand
    dfe_cand_unit #(
      .SAMPLE_W(SAMPLE_W),
      .TAP_W   (TAP_W),
      .NUM_TAPS(NUM_TAPS),
      .PATTERN (j)
    ) uCand (
      .sampleIn  (sampleIn),
      .tapWeights(tapWeights),
      .signBit   (candSign[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      candReg <= '0;
    else if (strobe.loadCand)
      candReg <= candSign;
  end

  // Recursive path: history register -> multiplexer -> history register
  assign pickBit = candReg[histState];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histState   <= '0;
      decisionBit <= 1'b0;
    end else if (strobe.commit) begin
      histState   <= {pickBit, histState[NUM_TAPS-1:1]};
      decisionBit <= pickBit;
    end
  end
endmodule

// File: rtl/dfe_unrolled.sv
module dfe_unrolled #(
  parameter int SAMPLE_W = 8,
  parameter int TAP_W    = 6,
  parameter int NUM_TAPS = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sampleValid,
  input  logic signed [SAMPLE_W-1:0]       sampleIn,
  input  logic        [NUM_TAPS*TAP_W-1:0] tapWeights,
  output logic                             decisionValid,
  output logic                             decisionBit
);
  dfe_pkg::dfe_strobe_t strobe;
  logic [NUM_TAPS-1:0]  histState;

  dfe_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .strobe       (strobe),
    .decisionValid(decisionValid)
  );

  dfe_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .TAP_W   (TAP_W),
    .NUM_TAPS(NUM_TAPS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampleIn   (sampleIn),
    .tapWeights (tapWeights),
    .decisionBit(decisionBit),
    .histState  (histState)
  );
endmodule

// File: rtl/dfe_unrolled_chk.sv
// Assertion checker, needs NUM_TAPS >= 2
module dfe_unrolled_chk #(
  parameter int NUM_TAPS = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic                decisionValid,
  input logic                decisionBit,
  input logic [NUM_TAPS-1:0] histState
);
  // History rebuilt from the output port alone
  logic [NUM_TAPS-1:0] shadowHist;
  logic [NUM_TAPS-1:0] expectHist;

  always_ff @(posedge clk) begin
    if (!rstN) shadowHist <= '0;
    else       shadowHist <= expectHist;
  end

  assign expectHist = decisionValid ? {decisionBit, shadowHist[NUM_TAPS-1:1]} : shadowHist;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> ##2 decisionValid); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ##2 !decisionValid); // R4
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !decisionValid |-> $stable(decisionBit)); // R7
  AST_HIST_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    histState == expectHist); // R5
endmodule

bind dfe_unrolled dfe_unrolled_chk #(.NUM_TAPS(NUM_TAPS)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .sampleValid  (sampleValid),
  .decisionValid(decisionValid),
  .decisionBit  (decisionBit),
  .histState    (histState)
);

// File: tb/tb_dfe_unrolled.sv
`timescale 1ns/1ps
module tb_dfe_unrolled;
  localparam int SW = 8;
  localparam int TW = 6;
  localparam int N  = 6;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 sampleValid = 1'b0;
  logic signed [SW-1:0] sampleIn = '0;
  logic [N*TW-1:0]      tapWeights = '0;
  logic                 decisionValid;
  logic                 decisionBit;

  dfe_unrolled #(.SAMPLE_W(SW), .TAP_W(TW), .NUM_TAPS(N)) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .tapWeights(tapWeights), .decisionValid(decisionValid), .decisionBit(decisionBit)
  );

  always #4 clk = ~clk;  // 125 MHz

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  int    refHist [1:N];
  bit    expQ[$];
  string tagQ[$];
  bit    v1, v2;
  bit    lastBit;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit refDecide(int y, logic [N*TW-1:0] t);
    int acc = y;
    for (int k = 1; k <= N; k++) begin
      logic signed [TW-1:0] d;
      d = t[(k-1)*TW +: TW];
      acc = acc - int'(d) * refHist[k];
    end
    return acc >= 0;
  endfunction

  // One cycle: check outputs at the falling edge, then drive the next inputs
  task automatic step(bit v, int y, logic [N*TW-1:0] t, string tag);
    @(negedge clk);
    check(decisionValid == v2, "R3 valid timing", decisionValid, v2);
    if (decisionValid && expQ.size() > 0) begin
      bit e = expQ.pop_front();
      string tg = tagQ.pop_front();
      check(decisionBit == e, tg, decisionBit, e);
      lastBit = decisionBit;
    end else if (!decisionValid) begin
      check(decisionBit == lastBit, "R7 hold", decisionBit, lastBit);
    end
    sampleValid = v;
    sampleIn    = SW'(y);
    tapWeights  = t;
    if (v) begin
      bit e = refDecide(int'($signed(SW'(y))), t);
      expQ.push_back(e);
      tagQ.push_back(tag);
      for (int k = N; k > 1; k--) refHist[k] = refHist[k-1];
      refHist[1] = e ? 1 : -1;
    end
    v2 = v1;
    v1 = v;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expQ.delete();
    tagQ.delete();
    for (int k = 1; k <= N; k++) refHist[k] = -1;
    v1 = 0; v2 = 0; lastBit = 0;
    check(decisionValid == 1'b0, "R5 reset valid", decisionValid, 0);
    check(decisionBit == 1'b0, "R5 reset bit", decisionBit, 0);
  endtask

  function automatic logic [N*TW-1:0] randTaps();
    logic [N*TW-1:0] t;
    for (int k = 0; k < N; k++) t[k*TW +: TW] = TW'($urandom);
    return t;
  endfunction

  task automatic flush();
    repeat (4) step(1'b0, 0, tapWeights, "idle");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL R3 watchdog actual=%0d expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N*TW-1:0] t;
    logic [N*TW-1:0] tMin;
    logic [N*TW-1:0] tMax;
    void'($urandom(32'h5eed_d0fe));
    doReset();

    // R5: history starts at -1; d1 = 1, y = 0 gives +1, then -1
    t = '0;
    t[TW-1:0] = TW'(1);
    step(1'b1, 0, t, "R5 first decision");
    step(1'b1, 0, t, "R5 second decision");
    flush();

    // R2: zero taps, exact zero and minus one
    step(1'b1, 0, '0, "R2 zero is one");
    step(1'b1, -1, '0, "R2 minus one is zero");
    step(1'b1, 0, '0, "R2 zero again");
    flush();

    // R1: fixed random taps, back-to-back samples
    t = randTaps();
    for (int i = 0; i < 1500; i++)
      step(1'b1, int'($signed(SW'($urandom))), t, "R1 direct-form match");
    flush();

    // R4: random gaps
    t = randTaps();
    for (int i = 0; i < 1500; i++)
      step(($urandom % 2) == 0, int'($signed(SW'($urandom))), t, "R4 gaps");
    flush();

    // R6: weights change with every sample
    for (int i = 0; i < 1500; i++)
      step(($urandom % 4) != 0, int'($signed(SW'($urandom))), randTaps(), "R6 per-sample taps");
    flush();

    // R8: extremes
    for (int k = 0; k < N; k++) begin
      tMin[k*TW +: TW] = {1'b1, {(TW-1){1'b0}}};
      tMax[k*TW +: TW] = {1'b0, {(TW-1){1'b1}}};
    end
    for (int i = 0; i < 400; i++) begin
      int y = ($urandom % 2) ? -(1 << (SW-1)) : (1 << (SW-1)) - 1;
      step(1'b1, y, ($urandom % 2) ? tMin : tMax, "R8 extremes");
    end
    flush();

    // R5 again: reset in the middle of a run
    t = randTaps();
    for (int i = 0; i < 20; i++) step(1'b1, int'($signed(SW'($urandom))), t, "R1 pre-reset");
    doReset();
    t = '0;
    t[TW-1:0] = TW'(1);
    step(1'b1, 0, t, "R5 after second reset");
    flush();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule